// File: doc/BRIEF.md
# Clock Frequency Select with Watchdog Recovery

This block is the control core of a programmable system clock generator. It decides which frequency configuration the PLL runs with: a 5-bit ratio/gear code, plus an N/M divider pair when programmable mode is on. The code comes from one of two places. One is a strap code captured from board pins. The other is a code written into a register. A one-cycle load strobe tells the PLL to take a new configuration.

A watchdog guards risky frequency changes. Once it is enabled, every new configuration restarts a countdown that advances on a prescaler tick. If the countdown runs out, the block pulses a system reset and switches the clock to a recovery configuration. That recovery configuration is either the strap code or a separate recovery N/M pair. The watchdog then stays stopped until the next configuration change.

Registers are written through a plain write port. A single write stores one byte. A paired write stores two consecutive registers in the same cycle: the low byte goes to the addressed register and the high byte to the next one. There is no streaming data path, so all pins are plain level or strobe signals with no back-pressure.

Top module: `fsel_wdog_ctrl`

## Requirements
- R1: After reset, all mode bits are 0 and the latched strap code is 0. The outputs are `cfg_prog_o`=0, `cfg_sel_o`=0, `cfg_n_o`=0 and `cfg_m_o`=0. `pll_load_o`, `sys_rst_o` and `in_recovery_o` are all 0.
- R2: The register map is: address 0 holds the mode bits, bit0 programmable, bit1 override, bit2 watchdog enable, bit3 recovery source. Address 1 holds SEL in [4:0]. Address 2 holds N[7:0] and address 3 holds M[6:0]. Address 4 holds the recovery N and address 5 the recovery M. With programmable mode off and override 0, `cfg_sel_o` follows the strap code captured on `strap_latch`, and `cfg_n_o`/`cfg_m_o` read 0.
- R3: With programmable mode off and override 1, `cfg_sel_o` equals SEL. A new strap latch then has no effect on the outputs.
- R4: With programmable mode on, `cfg_prog_o`=1 and `cfg_n_o`/`cfg_m_o` equal N/M. `cfg_sel_o` is still taken from the straps or from SEL according to the override bit.
- R5: `pll_load_o` is a one-cycle pulse. It comes in the cycle after the edge that stored the trigger, which is when the new configuration appears. Triggers are: any write to N, M, recovery N or recovery M; a mode write that changes a mode bit; and any change of the active configuration. A paired write of N and M gives exactly one pulse.
- R6: While the watchdog enable bit is 0, the timer is stopped and reloaded, and no tick produces a reset.
- R7: With the watchdog enabled, every load pulse other than a recovery switch re-arms the timer to `WD_RELOAD`. It expires on the `WD_RELOAD`-th tick after the last arming.
- R8: On expiry, `sys_rst_o` goes high for exactly `RST_CYCLES` cycles, and `in_recovery_o` rises at the same edge.
- R9: In recovery with the recovery source bit 0, the configuration is the strap code with `cfg_prog_o`=0. With the bit at 1, `cfg_prog_o`=1, N/M are the recovery fields, and the sel code follows the override choice. The switch produces a load pulse.
- R10: After expiry the watchdog stays stopped, and recovery holds, until a write to address 0, 1, 2 or 3. That write ends recovery at its own edge.
- R11: `strap_status_o` is {latched strap[4:0], 3'b011}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_in | input | 5 | Strap pin code |
| strap_latch | input | 1 | Capture `strap_in` at this edge |
| wr_en | input | 1 | Register write strobe |
| wr_pair | input | 1 | Also write the high byte to address+1 |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Low byte to address, high byte to address+1 |
| wd_tick | input | 1 | Prescaler tick for the watchdog |
| cfg_prog_o | output | 1 | N/M dividers in use |
| cfg_sel_o | output | 5 | Active ratio/gear code |
| cfg_n_o | output | 8 | Active N divider (0 when not programmable) |
| cfg_m_o | output | 7 | Active M divider (0 when not programmable) |
| pll_load_o | output | 1 | One-cycle PLL load strobe |
| sys_rst_o | output | 1 | Watchdog system reset pulse |
| in_recovery_o | output | 1 | Recovery configuration active |
| strap_status_o | output | 8 | Strap readback byte |

## Verification
The bench sweeps all 32 strap codes and all 32 SEL codes, and a spread of N/M pairs written as paired writes. It checks that a paired write gives one load strobe, not two, and that rewriting an unchanged N still produces a strobe. It counts ticks around a re-arm to catch a timer that does not reload: such a timer would fire one arming too early. It measures the reset pulse cycle by cycle. It checks both recovery sources, including the case where the sel code must follow the override bit. It also checks that the watchdog stays silent after recovery; a design that re-armed on the recovery switch would reset the system a second time.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int SEL_W  = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int NUM_REGS = 6;

  localparam int REG_MODE = 0;
  localparam int REG_SEL  = 1;
  localparam int REG_N    = 2;
  localparam int REG_M    = 3;
  localparam int REG_RN   = 4;
  localparam int REG_RM   = 5;

  typedef struct packed {
    logic rsel;
    logic wd_en;
    logic ovr;
    logic prog;
  } mode_t;

  typedef struct packed {
    logic             prog;
    logic [SEL_W-1:0] sel;
    logic [N_W-1:0]   n;
    logic [M_W-1:0]   m;
  } clk_cfg_t;
endpackage

// File: rtl/fsel_regs.sv
module fsel_regs
  import fsel_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_pair,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [LANES*BYTE_W-1:0] wr_data,
  input  logic                  strap_latch,
  input  logic [SEL_W-1:0]      strap_in,
  output mode_t                 mode_q,
  output logic [SEL_W-1:0]      sel_q,
  output logic [SEL_W-1:0]      strap_q,
  output logic [N_W-1:0]        n_q,
  output logic [M_W-1:0]        m_q,
  output logic [N_W-1:0]        rn_q,
  output logic [M_W-1:0]        rm_q,
  output logic                  upd_q,
  output logic                  user_wr
);
  logic [NUM_REGS-1:0]    hit;
  logic [BYTE_W-1:0]      wbyte [NUM_REGS];
  logic [LANES-1:0]       lane_en;
  logic [ADDR_W-1:0]      lane_addr [LANES];

  // one lane per byte of a paired write
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l]   = wr_en & ((l == 0) | wr_pair);
    assign lane_addr[l] = wr_addr + ADDR_W'(l);
  end

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      hit[r]   = 1'b0;
      wbyte[r] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l] && (int'(lane_addr[l]) == r)) begin
          hit[r]   = 1'b1;
          wbyte[r] = wr_data[l*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  logic [BYTE_W-1:0] mode_byte, sel_byte, m_byte, rm_byte;
  assign mode_byte = wbyte[REG_MODE];
  assign sel_byte  = wbyte[REG_SEL];
  assign m_byte    = wbyte[REG_M];
  assign rm_byte   = wbyte[REG_RM];

  mode_t mode_d;
  assign mode_d = mode_t'(mode_byte[3:0]);

  logic mode_chg, div_wr;
  assign mode_chg = hit[REG_MODE] & (mode_d != mode_q);
  assign div_wr   = hit[REG_N] | hit[REG_M] | hit[REG_RN] | hit[REG_RM];
  assign user_wr  = hit[REG_MODE] | hit[REG_SEL] | hit[REG_N] | hit[REG_M];

  // upper bits of narrow registers are don't-care on write
  logic unused_hi;
  assign unused_hi = ^{mode_byte[7:4], sel_byte[7:5], m_byte[7], rm_byte[7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      sel_q   <= '0;
      strap_q <= '0;
      n_q     <= '0;
      m_q     <= '0;
      rn_q    <= '0;
      rm_q    <= '0;
      upd_q   <= 1'b0;
    end else begin
      if (hit[REG_MODE]) mode_q <= mode_d;
      if (hit[REG_SEL])  sel_q  <= sel_byte[SEL_W-1:0];
      if (hit[REG_N])    n_q    <= wbyte[REG_N];
      if (hit[REG_M])    m_q    <= m_byte[M_W-1:0] | M_W'(unused_hi & 1'b0);
      if (hit[REG_RN])   rn_q   <= wbyte[REG_RN];
      if (hit[REG_RM])   rm_q   <= rm_byte[M_W-1:0];
      if (strap_latch)   strap_q <= strap_in;
      upd_q <= div_wr | mode_chg;
    end
  end
endmodule

// File: rtl/fsel_cfgsel.sv
module fsel_cfgsel
  import fsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             ovr,
  input  logic             rsel,
  input  logic [SEL_W-1:0] sel_q,
  input  logic [SEL_W-1:0] strap_q,
  input  logic [N_W-1:0]   n_q,
  input  logic [M_W-1:0]   m_q,
  input  logic [N_W-1:0]   rn_q,
  input  logic [M_W-1:0]   rm_q,
  input  logic             upd_q,
  input  logic             rcv_active,
  output clk_cfg_t         cfg_q,
  output logic             pll_load_q,
  output logic             arm
);
  logic [SEL_W-1:0] ratio;
  clk_cfg_t         cfg_next;
  logic             rcv_seen_q, rcv_rise, load_d;

  assign ratio = ovr ? sel_q : strap_q;

  always_comb begin
    if (rcv_active) begin
      if (rsel) cfg_next = '{prog: 1'b1, sel: ratio, n: rn_q, m: rm_q};
      else      cfg_next = '{prog: 1'b0, sel: strap_q, n: '0, m: '0};
    end else if (prog_en) begin
      cfg_next = '{prog: 1'b1, sel: ratio, n: n_q, m: m_q};
    end else begin
      cfg_next = '{prog: 1'b0, sel: ratio, n: '0, m: '0};
    end
  end

  assign rcv_rise = rcv_active & ~rcv_seen_q;
  assign load_d   = upd_q | rcv_rise | (cfg_next != cfg_q);
  assign arm      = load_d & ~rcv_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      pll_load_q <= 1'b0;
      rcv_seen_q <= 1'b0;
    end else begin
      cfg_q      <= cfg_next;
      pll_load_q <= load_d;
      rcv_seen_q <= rcv_active;
    end
  end
endmodule

// File: rtl/fsel_wdog.sv
module fsel_wdog #(
  parameter int WD_W       = 16,
  parameter int WD_RELOAD  = 1000,
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_en,
  input  logic tick,
  input  logic arm,
  input  logic user_wr,
  output logic rcv_active,
  output logic sys_rst
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [WD_W-1:0] RELOAD = WD_W'(WD_RELOAD);

  logic            running;
  logic [WD_W-1:0] cnt;
  logic [RC_W-1:0] rst_cnt;
  logic            expire;

  assign expire  = running & tick & (cnt == WD_W'(1));
  assign sys_rst = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      cnt        <= RELOAD;
      rcv_active <= 1'b0;
      rst_cnt    <= '0;
    end else begin
      if (!wd_en) begin
        running <= 1'b0;
        cnt     <= RELOAD;
      end else if (arm) begin
        running <= 1'b1;
        cnt     <= RELOAD;
      end else if (expire) begin
        running <= 1'b0;
        cnt     <= RELOAD;
      end else if (running && tick) begin
        cnt <= cnt - WD_W'(1);
      end

      if (wd_en && !arm && expire) begin
        rcv_active <= 1'b1;
        rst_cnt    <= RC_W'(RST_CYCLES);
      end else begin
        if (user_wr) rcv_active <= 1'b0;
        if (rst_cnt != '0) rst_cnt <= rst_cnt - RC_W'(1);
      end
    end
  end
endmodule

// File: rtl/fsel_wdog_ctrl.sv
module fsel_wdog_ctrl
  import fsel_pkg::*;
#(
  parameter int WD_W       = 16,
  parameter int WD_RELOAD  = 1000,
  parameter int RST_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  strap_in,
  input  logic        strap_latch,
  input  logic        wr_en,
  input  logic        wr_pair,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        wd_tick,
  output logic        cfg_prog_o,
  output logic [4:0]  cfg_sel_o,
  output logic [7:0]  cfg_n_o,
  output logic [6:0]  cfg_m_o,
  output logic        pll_load_o,
  output logic        sys_rst_o,
  output logic        in_recovery_o,
  output logic [7:0]  strap_status_o
);
  mode_t            mode_q;
  logic [SEL_W-1:0] sel_q, strap_q;
  logic [N_W-1:0]   n_q, rn_q;
  logic [M_W-1:0]   m_q, rm_q;
  logic             upd_q, user_wr, arm, rcv_active;
  clk_cfg_t         cfg_q;

  fsel_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_pair, .wr_addr, .wr_data,
    .strap_latch, .strap_in,
    .mode_q, .sel_q, .strap_q, .n_q, .m_q, .rn_q, .rm_q,
    .upd_q, .user_wr
  );

  fsel_cfgsel u_sel (
    .clk, .rst_n,
    .prog_en(mode_q.prog), .ovr(mode_q.ovr), .rsel(mode_q.rsel),
    .sel_q, .strap_q, .n_q, .m_q, .rn_q, .rm_q,
    .upd_q, .rcv_active,
    .cfg_q, .pll_load_q(pll_load_o), .arm
  );

  fsel_wdog #(.WD_W(WD_W), .WD_RELOAD(WD_RELOAD), .RST_CYCLES(RST_CYCLES)) u_wd (
    .clk, .rst_n, .wd_en(mode_q.wd_en), .tick(wd_tick), .arm, .user_wr,
    .rcv_active, .sys_rst(sys_rst_o)
  );

  assign cfg_prog_o     = cfg_q.prog;
  assign cfg_sel_o      = cfg_q.sel;
  assign cfg_n_o        = cfg_q.n;
  assign cfg_m_o        = cfg_q.m;
  assign in_recovery_o  = rcv_active;
  assign strap_status_o = {strap_q, 3'b011};
endmodule

// File: rtl/fsel_wdog_ctrl_chk.sv
module fsel_wdog_ctrl_chk #(
  parameter int RST_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_prog_o,
  input logic [4:0] cfg_sel_o,
  input logic [7:0] cfg_n_o,
  input logic [6:0] cfg_m_o,
  input logic       pll_load_o,
  input logic       sys_rst_o,
  input logic       in_recovery_o
);
  logic [15:0] rst_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rst_len <= '0;
    else if (sys_rst_o) rst_len <= rst_len + 16'd1;
    else                rst_len <= '0;
  end

  // R5
  cfg_change_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_prog_o, cfg_sel_o, cfg_n_o, cfg_m_o}) |-> pll_load_o);

  // R8
  rst_with_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $rose(in_recovery_o));

  // R8
  rst_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (rst_len == 16'(RST_CYCLES)));

  // R9
  recovery_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_recovery_o) |=> pll_load_o);

  // R2
  divider_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_o |-> (cfg_n_o == 8'd0 && cfg_m_o == 7'd0));
endmodule

bind fsel_wdog_ctrl fsel_wdog_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_prog_o(cfg_prog_o), .cfg_sel_o(cfg_sel_o),
  .cfg_n_o(cfg_n_o), .cfg_m_o(cfg_m_o), .pll_load_o(pll_load_o),
  .sys_rst_o(sys_rst_o), .in_recovery_o(in_recovery_o)
);

// File: tb/fsel_wdog_ctrl_bench.sv
module fsel_wdog_ctrl_bench;
  localparam int WD = 4;
  localparam int RC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [4:0]  strap_in = '0;
  logic        strap_latch = 1'b0;
  logic        wr_en = 1'b0, wr_pair = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wd_tick = 1'b0;
  logic        cfg_prog_o, pll_load_o, sys_rst_o, in_recovery_o;
  logic [4:0]  cfg_sel_o;
  logic [7:0]  cfg_n_o, strap_status_o;
  logic [6:0]  cfg_m_o;

  fsel_wdog_ctrl #(.WD_W(16), .WD_RELOAD(WD), .RST_CYCLES(RC)) u_fsel_wdog_ctrl (
    .clk, .rst_n, .strap_in, .strap_latch, .wr_en, .wr_pair, .wr_addr, .wr_data,
    .wd_tick, .cfg_prog_o, .cfg_sel_o, .cfg_n_o, .cfg_m_o, .pll_load_o,
    .sys_rst_o, .in_recovery_o, .strap_status_o
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_pair = 1'b0; wr_addr = 3'(a); wr_data = {8'h00, 8'(d)};
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr2(int a, int lo, int hi);
    wr_en = 1'b1; wr_pair = 1'b1; wr_addr = 3'(a); wr_data = {8'(hi), 8'(lo)};
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_pair = 1'b0;
  endtask

  task automatic latch(int v);
    strap_in = 5'(v); strap_latch = 1'b1;
    @(posedge clk); @(negedge clk);
    strap_latch = 1'b0;
  endtask

  task automatic tick1();
    wd_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    wd_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int prev;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 prog", cfg_prog_o, 0);
    check("R1 sel", cfg_sel_o, 0);
    check("R1 n", cfg_n_o, 0);
    check("R1 m", cfg_m_o, 0);
    check("R1 load", pll_load_o, 0);
    check("R1 rst", sys_rst_o, 0);
    check("R1 recovery", in_recovery_o, 0);
    check("R11 status reset", strap_status_o, 3);

    // R2 sweep all strap codes
    prev = 0;
    for (int v = 0; v < 32; v++) begin
      latch(v);
      check("R11 status", strap_status_o, v * 8 + 3);
      step();
      check("R2 sel from straps", cfg_sel_o, v);
      check("R5 load on strap change", pll_load_o, (v != prev) ? 1 : 0);
      prev = v;
    end
    step();
    check("R5 load single pulse", pll_load_o, 0);
    latch(5);
    step();

    // R3 override selects SEL
    wr(0, 2);
    step();
    check("R5 load on mode change", pll_load_o, 1);
    check("R3 sel after override", cfg_sel_o, 0);
    prev = 0;
    for (int v = 0; v < 32; v++) begin
      wr(1, v);
      step();
      check("R3 sel from register", cfg_sel_o, v);
      check("R5 load on sel change", pll_load_o, (v != prev) ? 1 : 0);
      prev = v;
    end
    latch(9);
    step();
    check("R3 strap ignored", cfg_sel_o, 31);
    check("R3 strap ignored load", pll_load_o, 0);

    // R4 programmable mode
    wr(0, 3);
    step();
    check("R4 prog", cfg_prog_o, 1);
    check("R4 sel kept", cfg_sel_o, 31);
    check("R5 load prog on", pll_load_o, 1);
    for (int i = 0; i < 16; i++) begin
      int nv, mv;
      nv = (i * 37 + 11) % 256;
      mv = (i * 53 + 3) % 128;
      wr2(2, nv, mv);
      step();
      check("R4 n", cfg_n_o, nv);
      check("R4 m", cfg_m_o, mv);
      check("R5 paired write load", pll_load_o, 1);
      step();
      check("R5 paired write one pulse", pll_load_o, 0);
    end
    wr(2, (15 * 37 + 11) % 256);
    step();
    check("R5 same-value N write loads", pll_load_o, 1);
    wr(0, 1);
    step();
    check("R4 ratio from straps", cfg_sel_o, 9);
    check("R4 prog kept", cfg_prog_o, 1);

    // R6 watchdog disabled
    wr2(4, 8'h44, 8'h22);
    step();
    for (int i = 0; i < 3 * WD; i++) begin
      tick1();
      check("R6 no reset when disabled", sys_rst_o, 0);
    end

    // R7 arm, reload, expire; R8 pulse; R9 strap recovery
    wr(0, 5);
    step();
    for (int i = 0; i < WD - 1; i++) begin
      tick1();
      check("R7 before expiry", sys_rst_o, 0);
    end
    wr(2, 8'h10);
    step();
    for (int i = 0; i < WD - 1; i++) begin
      tick1();
      check("R7 reloaded by change", sys_rst_o, 0);
    end
    tick1();
    check("R8 reset at expiry", sys_rst_o, 1);
    check("R8 recovery at expiry", in_recovery_o, 1);
    step();
    check("R9 strap recovery prog", cfg_prog_o, 0);
    check("R9 strap recovery sel", cfg_sel_o, 9);
    check("R9 recovery load", pll_load_o, 1);
    check("R8 reset cycle 2", sys_rst_o, 1);
    step();
    check("R8 reset cycle 3", sys_rst_o, 1);
    step();
    check("R8 reset ends", sys_rst_o, 0);
    for (int i = 0; i < WD + 2; i++) begin
      tick1();
      check("R10 stopped after recovery", sys_rst_o, 0);
    end
    check("R10 recovery held", in_recovery_o, 1);

    // R10 exit on write
    wr(2, 8'h20);
    check("R10 recovery cleared", in_recovery_o, 0);
    step();
    check("R10 back to programmed n", cfg_n_o, 8'h20);
    check("R10 back prog", cfg_prog_o, 1);

    // R9 recovery from recovery fields
    wr(0, 15);
    step();
    for (int i = 0; i < WD; i++) tick1();
    check("R8 second expiry", sys_rst_o, 1);
    step();
    check("R9 field recovery prog", cfg_prog_o, 1);
    check("R9 field recovery n", cfg_n_o, 8'h44);
    check("R9 field recovery m", cfg_m_o, 8'h22);
    check("R9 field recovery sel", cfg_sel_o, 31);
    check("R9 field recovery load", pll_load_o, 1);
    repeat (RC + 1) step();
    wr(0, 0);
    step();
    check("R10 exit recovery", in_recovery_o, 0);
    check("R2 back to straps", cfg_sel_o, 9);
    check("R2 dividers zero", cfg_n_o, 0);

    finish_run();
  end
endmodule